// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

The block is a bank of four hardware counters reached through a simple register port. The port has an address, write data, a write strobe and a read data bus. Three of the counters count down and can raise an interrupt. Two of these are narrow (16 bits) and one is wide (32 bits). Each counter advances on one of two tick-enable inputs, a slow one and a fast one, and a bit in its control register chooses which. When a counter passes zero it either reloads from its load register (periodic mode) or wraps to all-ones. In both cases it raises its interrupt line. The line stays high until software writes any value to that channel's clear register.

The fourth counter is 40 bits wide and counts upward on its own tick input. It has no interrupt. It is started and stopped by one enable bit. That bit sits in the same register that returns the counter's upper eight bits. Typical use is one periodic channel as the system heartbeat, with the 40-bit counter as a fine timestamp for measuring time between heartbeats.

Reads are combinational from registered state. A write takes effect at the clock edge on which the strobe is sampled. The tick enables are plain inputs: clock division and interrupt routing belong to the surrounding logic.

Top module: `cdt_bank`

## Requirements
- R1: After reset every load, count and control register, the 40-bit counter and its enable are zero, all interrupt lines are low, and every register address reads zero.
- R2: Writing a channel's load register (channel base + 0x0) sets both its load value and its current count (base + 0x4) at the same edge; this write takes priority over a tick in that cycle.
- R3: A channel with enable (control bit 7) set decrements by one on each cycle in which its selected tick is high; with enable clear, or with no selected tick, the count holds.
- R4: Control bit 3 selects the tick: 1 uses the fast tick input, 0 the slow one; the tick that is not selected has no effect on that channel.
- R5: With periodic mode (control bit 6) set, a tick at count zero reloads the load value and raises the channel's interrupt, so a load of N gives an interrupt every N+1 ticks.
- R6: With periodic mode clear, a tick at count zero wraps the count to all-ones (0xFFFF for the 16-bit channels, 0xFFFFFFFF for the 32-bit one) and raises the interrupt.
- R7: A write of any value to a channel's clear register (base + 0xC) lowers its interrupt; an underflow in the same cycle wins and leaves it high.
- R8: Channels 1 and 2 (bases 0x00, 0x20) are 16 bits and keep only the low 16 bits of a load; channel 3 (base 0x80) is 32 bits; the control register reads back only bits 7, 6 and 3, others zero.
- R9: Writing 1 to bit 8 of address 0x64 enables the 40-bit counter, which then increments on each cycle with its own tick high; 0x60 reads its low 32 bits and 0x64 reads the upper 8 bits in [7:0] with the enable in bit 8.
- R10: Writing 0 to bit 8 of 0x64 stops the 40-bit counter and clears it to zero; while disabled it stays zero, and the slow and fast ticks never advance it.
- R11: Unmapped addresses (any address whose bit 4 is set, group 0x40, 0xA0 to 0xE0, and the unused words of the 40-bit counter) read zero and ignore writes; a channel's clear register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register, low two bits ignored |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle when high |
| reg_rdata | output | 32 | Read data for reg_addr, from registered state |
| tick_slow | input | 1 | Slow tick enable for the down counters |
| tick_fast | input | 1 | Fast tick enable for the down counters |
| tick_free | input | 1 | Tick enable for the 40-bit up counter |
| irq | output | 3 | Interrupt per down-counting channel, bit 0 is channel 1 |

## Verification
The counters are driven with slow-only, fast-only, free-only and mixed tick patterns. This shows that each channel follows only its selected tick and that the 40-bit counter follows only its own. Periodic and wrapping underflows are both run, on the narrow and on the wide channel. The reload value, the all-ones wrap width and the N+1 period are told apart by reading the count on the cycles around zero. Collisions are run on purpose: a load write in the same cycle as a tick, and a clear write in the same cycle as an underflow. These fix the priorities. A mid-run reset and writes to unmapped words confirm that nothing leaks into the mapped registers.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NCH      = 3;
    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int FREE_W   = 40;

    // control bit positions (software-visible)
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_PER_BIT  = 6;
    localparam int CTL_FAST_BIT = 3;
    localparam int FREE_EN_BIT  = 8;

    // word index inside a channel group
    localparam logic [1:0] RG_LOAD = 2'd0;
    localparam logic [1:0] RG_CNT  = 2'd1;
    localparam logic [1:0] RG_CTL  = 2'd2;
    localparam logic [1:0] RG_CLR  = 2'd3;

    localparam logic [ADDR_W-1:0] FREE_BASE = 8'h60;

    typedef struct packed {
        logic en;
        logic per;
        logic fast;
    } ctl_t;

    function automatic logic [ADDR_W-1:0] chan_base(input int idx);
        case (idx)
            0:       return 8'h00;
            1:       return 8'h20;
            default: return 8'h80;
        endcase
    endfunction

    function automatic int chan_width(input int idx);
        return (idx == NCH - 1) ? WIDE_W : NARROW_W;
    endfunction
endpackage

// File: rtl/cdt_chan.sv
module cdt_chan
    import cdt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              wr_load,
    input  logic              wr_ctl,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    typedef struct packed {
        logic [W-1:0] load;
        logic [W-1:0] cnt;
        ctl_t         ctl;
        logic         irq;
    } st_t;

    st_t  st_d, st_q;
    logic tk_sel;
    logic step;
    logic at_zero;
    logic uflow;

    always_comb begin
        st_d    = st_q;
        tk_sel  = st_q.ctl.fast ? tick_fast : tick_slow;
        step    = st_q.ctl.en && tk_sel;
        at_zero = (st_q.cnt == '0);
        uflow   = step && at_zero;

        if (step) begin
            if (at_zero) st_d.cnt = st_q.ctl.per ? st_q.load : '1;
            else         st_d.cnt = st_q.cnt - 1'b1;
        end
        if (wr_clr) st_d.irq = 1'b0;
        if (uflow)  st_d.irq = 1'b1;
        if (wr_ctl) begin
            st_d.ctl.en   = wdata[CTL_EN_BIT];
            st_d.ctl.per  = wdata[CTL_PER_BIT];
            st_d.ctl.fast = wdata[CTL_FAST_BIT];
        end
        if (wr_load) begin
            st_d.load = wdata[W-1:0];
            st_d.cnt  = wdata[W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        case (rd_sel)
            RG_LOAD: rd_data = DATA_W'(st_q.load);
            RG_CNT:  rd_data = DATA_W'(st_q.cnt);
            RG_CTL: begin
                rd_data[CTL_EN_BIT]   = st_q.ctl.en;
                rd_data[CTL_PER_BIT]  = st_q.ctl.per;
                rd_data[CTL_FAST_BIT] = st_q.ctl.fast;
            end
            default: rd_data = '0;
        endcase
    end

    assign irq = st_q.irq;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    // R5: periodic underflow reloads and flags
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_zero && st_q.ctl.per && !wr_load)
        |=> (st_q.cnt == $past(st_q.load)) && st_q.irq);

    // R6: non-periodic underflow wraps to all-ones and flags
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_zero && !st_q.ctl.per && !wr_load)
        |=> (st_q.cnt == {W{1'b1}}) && st_q.irq);

    // R3: no selected tick or disabled means the count holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !wr_load) |=> $stable(st_q.cnt));

    // R7: a clear without coincident underflow drops the line
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_clr && !uflow) |=> !irq);

    // R2: a load write sets the count at the next edge
    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_load |=> (st_q.cnt == $past(wdata[W-1:0])));
endmodule

// File: rtl/cdt_free.sv
module cdt_free
    import cdt_pkg::*;
#(
    parameter int W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_ctl,
    input  logic              en_val,
    output logic [DATA_W-1:0] rd_lo,
    output logic [DATA_W-1:0] rd_hi
);
    localparam int HI_W = W - DATA_W;

    typedef struct packed {
        logic         en;
        logic [W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.en && tick) st_d.cnt = st_q.cnt + 1'b1;
        if (wr_ctl) begin
            st_d.en = en_val;
            if (!en_val) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_lo = st_q.cnt[DATA_W-1:0];
        rd_hi = '0;
        rd_hi[HI_W-1:0]     = st_q.cnt[W-1:DATA_W];
        rd_hi[FREE_EN_BIT]  = st_q.en;
    end

    // R10: a stopped counter always holds zero
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |-> (st_q.cnt == '0));

    // R9: an enabled counter steps by one on its own tick
    a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en && tick && !wr_ctl) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R9: without its tick the counter holds
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_ctl) |=> $stable(st_q.cnt));
endmodule

// File: rtl/cdt_bank.sv
module cdt_bank
    import cdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_we,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_slow,
    input  logic              tick_fast,
    input  logic              tick_free,
    output logic [NCH-1:0]    irq
);
    logic [1:0]        word_sel;
    logic [DATA_W-1:0] ch_rd [NCH];
    logic [NCH-1:0]    ch_hit;
    logic              free_hit;
    logic [DATA_W-1:0] free_lo, free_hi;

    assign word_sel = reg_addr[3:2];

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            localparam int                CW   = chan_width(i);
            localparam logic [ADDR_W-1:0] BASE = chan_base(i);
            logic [DATA_W-1:0] rd_raw;

            assign ch_hit[i] = (reg_addr[7:5] == BASE[7:5]) && !reg_addr[4];

            cdt_chan #(.W(CW)) u_chan (
                .clk      (clk),
                .rst_n    (rst_n),
                .tick_slow(tick_slow),
                .tick_fast(tick_fast),
                .wr_load  (reg_we && ch_hit[i] && (word_sel == RG_LOAD)),
                .wr_ctl   (reg_we && ch_hit[i] && (word_sel == RG_CTL)),
                .wr_clr   (reg_we && ch_hit[i] && (word_sel == RG_CLR)),
                .wdata    (reg_wdata),
                .rd_sel   (word_sel),
                .rd_data  (rd_raw),
                .irq      (irq[i])
            );

            assign ch_rd[i] = ch_hit[i] ? rd_raw : '0;
        end
    endgenerate

    assign free_hit = (reg_addr[7:5] == FREE_BASE[7:5]) && !reg_addr[4];

    cdt_free #(.W(FREE_W)) u_free (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_free),
        .wr_ctl(reg_we && free_hit && (word_sel == 2'd1)),
        .en_val(reg_wdata[FREE_EN_BIT]),
        .rd_lo (free_lo),
        .rd_hi (free_hi)
    );

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NCH; i++) reg_rdata = reg_rdata | ch_rd[i];
        if (free_hit && word_sel == 2'd0) reg_rdata = reg_rdata | free_lo;
        if (free_hit && word_sel == 2'd1) reg_rdata = reg_rdata | free_hi;
    end

    logic unused_addr;
    assign unused_addr = ^reg_addr[1:0];

    // R11: at most one register group decodes any address
    a_r11_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ch_hit, free_hit}));

    // R11: an unmapped address returns zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ({ch_hit, free_hit} == '0) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_cdt_bank.sv
module sim_cdt_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        tick_slow = 1'b0, tick_fast = 1'b0, tick_free = 1'b0;
    logic [2:0]  irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    cdt_bank u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .tick_slow(tick_slow),
        .tick_fast(tick_fast), .tick_free(tick_free), .irq(irq)
    );

    // tk: [0] slow, [1] fast, [2] free
    typedef struct packed {
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [2:0]  tk;
        logic        crd;
        logic        cirq;
        logic [31:0] exp;
        logic [2:0]  eirq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 46;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b1, 32'h0,        3'b000, 4'd1 },  // R1
        '{1'b1, 8'h00, 32'h12345,    3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd8 },
        '{1'b0, 8'h00, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2345,     3'b000, 4'd8 },  // R8
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2345,     3'b000, 4'd2 },  // R2
        '{1'b0, 8'h00, 32'h0,        3'b001, 1'b0, 1'b0, 32'h0,        3'b000, 4'd3 },
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2345,     3'b000, 4'd3 },  // R3
        '{1'b1, 8'h08, 32'hFFFFFFFF, 3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd8 },
        '{1'b0, 8'h08, 32'h0,        3'b000, 1'b1, 1'b0, 32'hC8,       3'b000, 4'd8 },  // R8
        '{1'b1, 8'h08, 32'hC0,       3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd5 },
        '{1'b1, 8'h00, 32'h2,        3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd5 },
        '{1'b0, 8'h00, 32'h0,        3'b010, 1'b0, 1'b0, 32'h0,        3'b000, 4'd4 },
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2,        3'b000, 4'd4 },  // R4
        '{1'b0, 8'h00, 32'h0,        3'b001, 1'b0, 1'b0, 32'h0,        3'b000, 4'd3 },
        '{1'b0, 8'h00, 32'h0,        3'b001, 1'b0, 1'b0, 32'h0,        3'b000, 4'd3 },
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b1, 32'h0,        3'b000, 4'd5 },  // R5
        '{1'b0, 8'h00, 32'h0,        3'b001, 1'b0, 1'b0, 32'h0,        3'b000, 4'd5 },
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b1, 32'h2,        3'b001, 4'd5 },  // R5
        '{1'b1, 8'h0C, 32'h0,        3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd7 },
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b1, 32'h2,        3'b000, 4'd7 },  // R7
        '{1'b1, 8'h20, 32'h1,        3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b1, 8'h28, 32'h88,       3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b0, 8'h00, 32'h0,        3'b010, 1'b0, 1'b0, 32'h0,        3'b000, 4'd4 },
        '{1'b0, 8'h00, 32'h0,        3'b010, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b0, 8'h24, 32'h0,        3'b000, 1'b1, 1'b1, 32'hFFFF,     3'b010, 4'd6 },  // R6
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2,        3'b000, 4'd4 },  // R4
        '{1'b1, 8'h80, 32'h0,        3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b1, 8'h88, 32'h80,       3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b0, 8'h00, 32'h0,        3'b001, 1'b0, 1'b0, 32'h0,        3'b000, 4'd6 },
        '{1'b0, 8'h84, 32'h0,        3'b000, 1'b1, 1'b1, 32'hFFFFFFFF, 3'b110, 4'd6 },  // R6
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h1,        3'b000, 4'd3 },  // R3
        '{1'b1, 8'h2C, 32'h5A,       3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd7 },
        '{1'b0, 8'h24, 32'h0,        3'b000, 1'b1, 1'b1, 32'hFFFF,     3'b100, 4'd7 },  // R7
        '{1'b1, 8'h40, 32'hDEAD,     3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd11},
        '{1'b0, 8'h40, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd11},  // R11
        '{1'b0, 8'h0C, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd11},  // R11
        '{1'b0, 8'h60, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd1 },  // R1
        '{1'b0, 8'h00, 32'h0,        3'b100, 1'b0, 1'b0, 32'h0,        3'b000, 4'd10},
        '{1'b0, 8'h60, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd10},  // R10
        '{1'b1, 8'h64, 32'h100,      3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd9 },
        '{1'b0, 8'h64, 32'h0,        3'b000, 1'b1, 1'b0, 32'h100,      3'b000, 4'd9 },  // R9
        '{1'b0, 8'h00, 32'h0,        3'b100, 1'b0, 1'b0, 32'h0,        3'b000, 4'd9 },
        '{1'b0, 8'h00, 32'h0,        3'b101, 1'b0, 1'b0, 32'h0,        3'b000, 4'd9 },
        '{1'b0, 8'h60, 32'h0,        3'b000, 1'b1, 1'b0, 32'h2,        3'b000, 4'd9 },  // R9
        '{1'b0, 8'h04, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd3 },  // R3
        '{1'b1, 8'h64, 32'h0,        3'b000, 1'b0, 1'b0, 32'h0,        3'b000, 4'd10},
        '{1'b0, 8'h60, 32'h0,        3'b000, 1'b1, 1'b0, 32'h0,        3'b000, 4'd10}   // R10
    };

    task automatic chk_rd(input int rq, input logic [31:0] exp);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL R%0d addr %02h rdata actual %08h expected %08h", rq, reg_addr, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input int rq, input logic [2:0] exp);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL R%0d irq actual %03b expected %03b", rq, irq, exp);
        end
    endtask

    // one cycle: drive at negedge, committed at the following posedge
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d, input logic [2:0] tk);
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d;
        {tick_free, tick_fast, tick_slow} = tk;
    endtask

    task automatic rd(input int rq, input logic [7:0] a, input logic [31:0] exp);
        cyc(1'b0, a, 32'h0, 3'b000);
        #1 chk_rd(rq, exp);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual %0d cycles expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            reg_we = VEC[k].we; reg_addr = VEC[k].addr; reg_wdata = VEC[k].data;
            {tick_free, tick_fast, tick_slow} = VEC[k].tk;
            #1;
            if (VEC[k].crd)  chk_rd(int'(VEC[k].req), VEC[k].exp);
            if (VEC[k].cirq) chk_irq(int'(VEC[k].req), VEC[k].eirq);
        end

        // R7: clear write colliding with an underflow keeps the line high
        cyc(1'b1, 8'h0C, 32'h1, 3'b001);
        cyc(1'b0, 8'h04, 32'h0, 3'b000);
        #1 chk_irq(7, 3'b101);          // R7 (channel 3 still flagged)
        chk_rd(5, 32'h2);               // R5 reload on that underflow

        // R2: load write beats a tick in the same cycle
        cyc(1'b1, 8'h00, 32'h7, 3'b001);
        rd(2, 8'h04, 32'h7);            // R2

        // R11: aliased address with bit 4 set is ignored
        cyc(1'b1, 8'h10, 32'h55, 3'b000);
        rd(11, 8'h00, 32'h7);           // R11
        rd(11, 8'h10, 32'h0);           // R11

        // R1: mid-run reset returns everything to zero
        @(negedge clk); rst_n = 1'b0; reg_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(1, 8'h00, 32'h0);            // R1
        rd(1, 8'h04, 32'h0);
        rd(1, 8'h08, 32'h0);
        rd(1, 8'h24, 32'h0);
        rd(1, 8'h84, 32'h0);
        rd(1, 8'h64, 32'h0);
        chk_irq(1, 3'b000);             // R1

        finish_run();
    end
endmodule